// File: doc/BRIEF.md
# Reset Source Status Recorder

This block records which event or events caused the most recent system reset. It keeps the result in an 8-bit status register that software can only read. Each reset source reaches the block as a one-cycle event strobe: power-on detect, low-voltage detect, the external active-low reset pin, watchdog timeout, PLL loss-of-lock, clock loss, and wakeup from the lowest-power mode. A separate qualifier strobe says that the wakeup came through the reset pin.

While the internal system reset `sys_rst_n` is low, the block collects every strobe it sees into a sticky window. The first clock edge that samples `sys_rst_n` high again turns that window into a status pattern and then clears the window. Power-on always produces exactly 0x82, so the low-voltage flag is set next to the power-on flag. A wakeup without power-on produces 0x41 when the pin qualifier was seen and 0x01 otherwise. Any other reset sets one flag for each source that was seen. The recorder's own reset `rst_n` is asserted only by the power-on circuit, and it loads 0x82.

Top module: `rst_cause_recorder`

## Requirements
- R1: While `rst_n` is sampled low, the status register is set to 0x82 and the reset window is cleared. After `rst_n` is released, a read returns 0x82 until the next reset release.
- R2: Field positions: bit 7 power-on, bit 6 pin, bit 5 watchdog, bit 4 reserved, bit 3 loss-of-lock, bit 2 clock loss, bit 1 low-voltage, bit 0 wakeup. A window with no power-on and no wakeup loads one bit for each source seen (pin, watchdog, loss-of-lock, clock loss, low-voltage). Bits 7 and 0 are 0, and several sources combine by OR.
- R3: A power-on strobe in the window loads exactly 0x82, whatever other strobes were seen.
- R4: A wakeup strobe with no power-on in the window loads 0x41 when the pin qualifier was seen anywhere in the window, and 0x01 otherwise. All other sources are then not shown.
- R5: A window that holds only a low-voltage strobe loads 0x02.
- R6: A watchdog strobe is recorded only if `wdog_en` is high in the same cycle. With `wdog_en` low it has no effect on the loaded value.
- R7: Bit 4 always reads 0.
- R8: Strobes are collected over every cycle in which `sys_rst_n` is sampled low. The new value is loaded at the first clock edge that samples `sys_rst_n` high after it was low. Before that edge a read still returns the previous value. The window is empty after the load.
- R9: Strobes seen while `sys_rst_n` is high are ignored, and the status register holds its value between reset releases.
- R10: `rd_data` is the status value, without a clock delay, when `rd_en` is high and `rd_addr` equals `REG_ADDR`. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the recorder, asserted by the power-on circuit only |
| sys_rst_n | input | 1 | Internal system reset, active low; its release loads the status register |
| ev_por | input | 1 | Power-on detect strobe |
| ev_lvd | input | 1 | Low-voltage detect strobe |
| ev_pin | input | 1 | External reset pin strobe |
| ev_wdog | input | 1 | Watchdog timeout strobe |
| wdog_en | input | 1 | Watchdog enabled; gates `ev_wdog` |
| ev_lol | input | 1 | PLL loss-of-lock strobe |
| ev_loc | input | 1 | Clock loss strobe |
| ev_wake | input | 1 | Low-power-mode wakeup strobe |
| ev_wake_pin | input | 1 | Qualifier: the wakeup came through the reset pin |
| rd_en | input | 1 | Register read enable |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | 8 | Read data |

## Verification
The bench sweeps all 256 combinations of the eight strobes, once with the watchdog enabled and once with it disabled. It places half of the strobes two cycles after the other half, so the wakeup and its pin qualifier often land in different cycles. Each case is compared with a value the bench computes itself.

Each corner case targets a specific fault:
- A design that lets any other source modify the power-on pattern fails R3.
- A design that drops the qualifier when it arrives in a different cycle from the wakeup fails R4.
- A design that records watchdog strobes while the watchdog is disabled fails R6.
- A design that loads one cycle early or late fails R8, which is checked before and after the release edge.
- A design that latches strobes outside the window fails R9.
- A design that leaves data on the bus for a wrong address fails R10.

// File: rtl/rst_cause_pkg.sv
// Package: shared field positions and event bundle for the reset cause recorder.
// Assumes an 8-bit status register whose bit positions are decoded by software.
package rst_cause_pkg;

    localparam int STAT_W   = 8;
    localparam int B_POR    = 7;
    localparam int B_PIN    = 6;
    localparam int B_WDOG   = 5;
    localparam int B_RSVD   = 4;
    localparam int B_LOL    = 3;
    localparam int B_LOC    = 2;
    localparam int B_LVD    = 1;
    localparam int B_WAKE   = 0;

    localparam logic [STAT_W-1:0] POR_PATTERN = 8'h82;

    // One flag per reset event; the field order is internal only.
    typedef struct packed {
        logic por;
        logic lvd;
        logic pin;
        logic wdog;
        logic lol;
        logic loc;
        logic wake;
        logic wake_pin;
    } rst_events_t;

    localparam int EV_W = $bits(rst_events_t);

endpackage

// File: rtl/rst_window_accum.sv
// Module: collects reset event strobes into sticky flags while the system
// reset is held low. It flags the first cycle the reset is seen released, and
// clears the flags on that cycle.
// Assumes: sys_rst_n is already synchronous to clk; strobes may be single cycle.
module rst_window_accum
    import rst_cause_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sys_rst_n,
    input  rst_events_t ev_in,
    input  logic        wdog_en,
    output rst_events_t window,
    output logic        release_now
);

    logic        sys_prev_q;
    rst_events_t gated;
    logic [EV_W-1:0] gated_vec;
    logic [EV_W-1:0] win_vec;

    // Purpose: drop watchdog strobes that arrive while the watchdog is disabled.
    always_comb begin
        gated      = ev_in;
        gated.wdog = ev_in.wdog & wdog_en;
    end

    assign gated_vec   = gated;
    assign release_now = sys_rst_n & ~sys_prev_q;

    // Purpose: remember last sampled system reset level for release detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sys_prev_q <= 1'b1;
        else        sys_prev_q <= sys_rst_n;
    end

    genvar g;
    generate
        for (g = 0; g < EV_W; g++) begin : g_flag
            // Purpose: sticky flag for one event, set in the window, cleared on release.
            always_ff @(posedge clk) begin
                if (!rst_n)            win_vec[g] <= 1'b0;
                else if (release_now)  win_vec[g] <= 1'b0;
                else if (!sys_rst_n)   win_vec[g] <= win_vec[g] | gated_vec[g];
            end
        end
    endgenerate

    assign window = win_vec;

    AST_WDOG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!window.wdog && !wdog_en) |=> !window.wdog);                      // R6
    AST_WINDOW_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        release_now |=> (window == '0));                                   // R8
    AST_NO_FILL_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_n && window == '0) |=> (window == '0));                   // R9

endmodule

// File: rtl/rst_cause_encoder.sv
// Module: maps the collected reset events to the status pattern.
// Precedence: power-on over wakeup over the OR of the remaining sources.
// Assumes: purely combinational, used only on the release cycle.
module rst_cause_encoder
    import rst_cause_pkg::*;
(
    input  rst_events_t       ev,
    output logic [STAT_W-1:0] pattern
);

    // Purpose: build the status byte from the event flags with fixed precedence.
    always_comb begin
        pattern = '0;
        if (ev.por) begin
            pattern = POR_PATTERN;
        end else if (ev.wake) begin
            pattern[B_WAKE] = 1'b1;
            pattern[B_PIN]  = ev.wake_pin;
        end else begin
            pattern[B_PIN]  = ev.pin;
            pattern[B_WDOG] = ev.wdog;
            pattern[B_LOL]  = ev.lol;
            pattern[B_LOC]  = ev.loc;
            pattern[B_LVD]  = ev.lvd;
        end
    end

endmodule

// File: rtl/rst_status_reg.sv
// Module: holds the status byte and serves the read-only register port.
// Assumes: load is a single-cycle pulse; the read path is combinational.
module rst_status_reg
    import rst_cause_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [STAT_W-1:0] load_val,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [STAT_W-1:0] status,
    output logic [STAT_W-1:0] rd_data
);

    logic hit;

    // Purpose: power-on value at block reset, new pattern on release, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     status <= POR_PATTERN;
        else if (load)  status <= load_val;
    end

    assign hit     = rd_en && (rd_addr == REG_ADDR);
    assign rd_data = hit ? status : '0;

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(status));                                        // R9
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !status[B_RSVD]);                                         // R7
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rd_data == '0));                                       // R10

endmodule

// File: rtl/rst_cause_recorder.sv
// Module: top of the reset cause recorder. It collects event strobes during
// system reset and loads the encoded cause on release. It offers the result
// as a read-only register.
// Assumes: rst_n comes only from power-on; all inputs are synchronous to clk.
module rst_cause_recorder
    import rst_cause_pkg::*;
#(
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_rst_n,
    input  logic              ev_por,
    input  logic              ev_lvd,
    input  logic              ev_pin,
    input  logic              ev_wdog,
    input  logic              wdog_en,
    input  logic              ev_lol,
    input  logic              ev_loc,
    input  logic              ev_wake,
    input  logic              ev_wake_pin,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    rst_events_t       ev_bus;
    rst_events_t       window;
    logic              release_now;
    logic [STAT_W-1:0] pattern;
    logic [STAT_W-1:0] status;

    // Purpose: bundle the separate strobe pins into one event record.
    always_comb begin
        ev_bus.por      = ev_por;
        ev_bus.lvd      = ev_lvd;
        ev_bus.pin      = ev_pin;
        ev_bus.wdog     = ev_wdog;
        ev_bus.lol      = ev_lol;
        ev_bus.loc      = ev_loc;
        ev_bus.wake     = ev_wake;
        ev_bus.wake_pin = ev_wake_pin;
    end

    rst_window_accum u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .sys_rst_n   (sys_rst_n),
        .ev_in       (ev_bus),
        .wdog_en     (wdog_en),
        .window      (window),
        .release_now (release_now)
    );

    rst_cause_encoder u_enc (
        .ev      (window),
        .pattern (pattern)
    );

    rst_status_reg #(
        .ADDR_W   (ADDR_W),
        .REG_ADDR (REG_ADDR)
    ) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (release_now),
        .load_val (pattern),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .status   (status),
        .rd_data  (rd_data)
    );

    AST_POR_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (release_now && window.por) |=> (status == 8'h82));                // R3
    AST_PIN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (release_now && !window.por && window.wake && window.wake_pin)
        |=> (status == 8'h41));                                            // R4
    AST_LOAD_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        release_now |=> (status == $past(pattern)));                       // R8

endmodule

// File: tb/rst_cause_recorder_test.sv
`timescale 1ns/1ps
module rst_cause_recorder_test;

    logic       clk = 1'b0;
    logic       rst_n, sys_rst_n;
    logic       ev_por, ev_lvd, ev_pin, ev_wdog, wdog_en;
    logic       ev_lol, ev_loc, ev_wake, ev_wake_pin;
    logic       rd_en;
    logic [3:0] rd_addr;
    logic [7:0] rd_data;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    rst_cause_recorder uut (
        .clk(clk), .rst_n(rst_n), .sys_rst_n(sys_rst_n),
        .ev_por(ev_por), .ev_lvd(ev_lvd), .ev_pin(ev_pin), .ev_wdog(ev_wdog),
        .wdog_en(wdog_en), .ev_lol(ev_lol), .ev_loc(ev_loc), .ev_wake(ev_wake),
        .ev_wake_pin(ev_wake_pin), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=0x%02h exp=0x%02h", req, got, exp);
        end
    endtask

    // m bits: 0 por,1 lvd,2 pin,3 wdog,4 lol,5 loc,6 wake,7 wake_pin
    function automatic logic [7:0] expect_of(input logic [7:0] m, input logic en);
        logic [7:0] v;
        if (m[0])      v = 8'd130;
        else if (m[6]) v = m[7] ? 8'd65 : 8'd1;
        else v = 8'd64 * m[2] + 8'd32 * (m[3] & en) + 8'd8 * m[4]
               + 8'd4 * m[5] + 8'd2 * m[1];
        return v;
    endfunction

    task automatic drive(input logic [7:0] m);
        ev_por = m[0]; ev_lvd = m[1]; ev_pin = m[2]; ev_wdog = m[3];
        ev_lol = m[4]; ev_loc = m[5]; ev_wake = m[6]; ev_wake_pin = m[7];
    endtask

    task automatic run_window(input logic [7:0] m, input logic en,
                              input logic [7:0] prev, input string req);
        @(negedge clk); sys_rst_n = 1'b0; wdog_en = en;
        @(negedge clk); drive(m & 8'h55);
        @(negedge clk); drive(8'h00);
        @(negedge clk); drive(m & 8'hAA);
        @(negedge clk); drive(8'h00);
        @(negedge clk); sys_rst_n = 1'b1;
        #1 check("R8 before release edge", rd_data, prev);
        @(negedge clk);
        check(req, rd_data, expect_of(m, en));
        check("R7 reserved bit", rd_data & 8'h10, 8'h00);
    endtask

    initial begin : watchdog
        while (!done && cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] prev;
        logic [7:0] e;
        rst_n = 1'b0; sys_rst_n = 1'b1; wdog_en = 1'b0; drive(8'h00);
        rd_en = 1'b1; rd_addr = 4'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", rd_data, 8'h82);
        rd_en = 1'b0;
        #1 check("R10 read disabled", rd_data, 8'h00);
        rd_en = 1'b1; rd_addr = 4'd3;
        #1 check("R10 wrong address", rd_data, 8'h00);
        rd_addr = 4'd0;
        // R9: strobes outside the window must not be latched
        wdog_en = 1'b1; drive(8'hFF);
        repeat (4) @(negedge clk);
        drive(8'h00);
        check("R9 hold while released", rd_data, 8'h82);
        run_window(8'h00, 1'b1, 8'h82, "R9 empty window after outside strobes");
        prev = 8'h00;
        run_window(8'h02, 1'b0, prev, "R5 low-voltage alone");
        prev = 8'h02;
        for (int en = 0; en < 2; en++) begin
            for (int m = 0; m < 256; m++) begin
                e = expect_of(m[7:0], en[0]);
                if (m[0])       run_window(m[7:0], en[0], prev, "R3 power-on pattern");
                else if (m[6])  run_window(m[7:0], en[0], prev, "R4 wakeup pattern");
                else if (m[3])  run_window(m[7:0], en[0], prev, "R6 watchdog gating");
                else            run_window(m[7:0], en[0], prev, "R2 combined sources");
                prev = e;
            end
        end
        drive(8'h7F);
        repeat (3) @(negedge clk);
        drive(8'h00);
        check("R9 hold after sweep", rd_data, prev);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule